// File: doc/BRIEF.md
# DDR Extended Mode Programming Sequencer

This controller-side block writes the extended mode register of a DDR SDRAM and takes care of the delay-locked loop (DLL) housekeeping that such a write implies. A requester pulses a request that carries two choices: whether the DLL should run, and whether the outputs should use normal or reduced drive. The sequencer stores the request and waits until the memory is quiet, meaning every bank is idle and no burst is in flight. It then drives a load-mode command that selects the extended register through the bank-address lines.

When the request turns the DLL on, a second load-mode command follows. This one goes to the base mode register with its DLL-reset bit set. Reads are also blocked for a fixed number of clock cycles so that the DLL can lock. Leaving self refresh turns the DLL back on by itself, so an exit pulse restarts the same read block. Every load-mode command is followed by a programmable number of NOP cycles before anything else is driven. Requests that arrive while a sequence is running wait in a one-deep slot, and the most recent request wins.

Top module: `ddr_xmode_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, cmd_o is NOP (3'b111), ba_o is 2'b00, addr_o is zero, busy_o is 0 and rd_ok_o is 0.
- R2: An extended register write drives cmd_o = LOAD (3'b000) and ba_o = 2'b01. On addr_o, bit 0 is the inverse of the DLL request (0 = DLL on, 1 = DLL off), bit 1 is the reduced-drive request (1 = reduced), and bits 11..2 are 0.
- R3: A stored request drives no command while banks_idle is low or burst_active is high. The write appears on cmd_o one cycle after the first clock edge at which both are quiet and a request is stored. With a quiet bus, that is on the second edge after req_valid is sampled.
- R4: Each load-mode command is followed by exactly GAP_CYC cycles of NOP before the next command.
- R5: After an extended write that turns the DLL on, the next command is LOAD with ba_o = 2'b00 and addr_o equal to BASE_FIELDS with bit DLL_RST_BIT (default 8) forced to 1.
- R6: A request that turns the DLL off drives only the extended write. After its GAP_CYC NOP cycles, busy_o falls, and rd_ok_o keeps its earlier value.
- R7: rd_ok_o is 0 in the cycle in which an extended write that turns the DLL on appears. It stays 0 for LOCK_CYC cycles in total and is 1 from the LOCK_CYC-th cycle after that appearance, unless the block is restarted.
- R8: A one-cycle pulse on sr_exit makes rd_ok_o 0 in the next cycle. It then returns to 1 exactly LOCK_CYC cycles after that point.
- R9: A request that arrives while a sequence runs does not disturb it. It is issued once the running sequence has finished, and if several arrive, only the latest is kept.
- R10: busy_o is 1 from the cycle after a request is sampled until the final NOP gap of its sequence ends. cmd_o is NOP whenever busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_dll_on | input | 1 | 1 = run the DLL, 0 = stop it |
| req_reduced | input | 1 | 1 = reduced output drive |
| banks_idle | input | 1 | All banks precharged |
| burst_active | input | 1 | A read or write burst is in progress |
| sr_exit | input | 1 | Pulse on leaving self refresh |
| cmd_o | output | 3 | Command bus {RAS#,CAS#,WE#}: 3'b111 NOP, 3'b000 LOAD |
| ba_o | output | 2 | Bank address, selects the register on LOAD |
| addr_o | output | ADDR_W | Address bus, carries the register value on LOAD |
| busy_o | output | 1 | A request is stored or a sequence is running |
| rd_ok_o | output | 1 | Reads are allowed (DLL lock time elapsed) |

## Verification
A wrong state in the sequencer shows on the command bus within a cycle or two. A sequencer that leaves its gap early drives a LOAD sooner than GAP_CYC NOP cycles allow. One that chooses the wrong path drops or adds the base register write that resets the DLL. A bad stored request shows in bits 1..0 of the extended write. Errors in the lock counter stay hidden longer, because they surface only at the end of the lockout, when rd_ok_o rises one cycle early or late. For that reason, rd_ok_o is sampled on both sides of that exact cycle, after a DLL enable and again after a self-refresh exit.

// File: rtl/xmode_pkg.sv
package xmode_pkg;
    typedef enum logic [2:0] {
        CMD_LOAD = 3'b000,
        CMD_NOP  = 3'b111
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GAP_X = 2'd1,
        ST_GAP_B = 2'd2
    } seq_st_e;

    localparam logic [1:0] BA_BASE = 2'b00;
    localparam logic [1:0] BA_EXT  = 2'b01;
endpackage

// File: rtl/xmode_word_build.sv
module xmode_word_build #(
    parameter int              ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] BASE_FIELDS = '0,
    parameter int              RST_BIT     = 8
) (
    input  logic              dll_on,
    input  logic              reduced,
    output logic [ADDR_W-1:0] ext_word,
    output logic [ADDR_W-1:0] base_word
);
    always_comb begin
        ext_word    = '0;
        ext_word[0] = ~dll_on;
        ext_word[1] = reduced;
        base_word          = BASE_FIELDS;
        base_word[RST_BIT] = 1'b1;
    end
endmodule

// File: rtl/xmode_req_hold.sv
module xmode_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_dll_on,
    input  logic req_reduced,
    input  logic take,
    output logic pend,
    output logic pend_dll,
    output logic pend_red
);
    typedef struct packed {
        logic vld;
        logic dll;
        logic red;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (req_valid) begin
            h_d.vld = 1'b1;
            h_d.dll = req_dll_on;
            h_d.red = req_reduced;
        end else if (take) begin
            h_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign pend     = h_q.vld;
    assign pend_dll = h_q.dll;
    assign pend_red = h_q.red;
endmodule

// File: rtl/xmode_lock_timer.sv
module xmode_lock_timer #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic rd_ok
);
    localparam int CW = $clog2(LOCK_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ok;
    } lock_t;

    lock_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (start) begin
            l_d.cnt = CW'(LOCK_CYC);
            l_d.ok  = 1'b0;
        end else if (l_q.cnt != '0) begin
            l_d.cnt = l_q.cnt - 1'b1;
            if (l_q.cnt == CW'(1)) l_d.ok = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign rd_ok = l_q.ok;
endmodule

// File: rtl/ddr_xmode_seq.sv
module ddr_xmode_seq
    import xmode_pkg::*;
#(
    parameter int                ADDR_W      = 12,
    parameter int                GAP_CYC     = 2,
    parameter int                LOCK_CYC    = 200,
    parameter int                DLL_RST_BIT = 8,
    parameter logic [ADDR_W-1:0] BASE_FIELDS = 12'h032
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_dll_on,
    input  logic              req_reduced,
    input  logic              banks_idle,
    input  logic              burst_active,
    input  logic              sr_exit,
    output logic [2:0]        cmd_o,
    output logic [1:0]        ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              rd_ok_o
);
    localparam int GW = $clog2(GAP_CYC + 1);

    typedef struct packed {
        seq_st_e           st;
        logic [GW-1:0]     gap;
        logic              dll;
        cmd_e              cmd;
        logic [1:0]        ba;
        logic [ADDR_W-1:0] addr;
        logic              busy;
    } seq_t;

    seq_t s_d, s_q;

    logic              pend, pend_dll, pend_red;
    logic              take, lock_start;
    logic [ADDR_W-1:0] ext_word, base_word;

    xmode_req_hold u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_dll_on  (req_dll_on),
        .req_reduced (req_reduced),
        .take        (take),
        .pend        (pend),
        .pend_dll    (pend_dll),
        .pend_red    (pend_red)
    );

    xmode_word_build #(
        .ADDR_W      (ADDR_W),
        .BASE_FIELDS (BASE_FIELDS),
        .RST_BIT     (DLL_RST_BIT)
    ) u_words (
        .dll_on    (pend_dll),
        .reduced   (pend_red),
        .ext_word  (ext_word),
        .base_word (base_word)
    );

    xmode_lock_timer #(
        .LOCK_CYC (LOCK_CYC)
    ) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .start (lock_start),
        .rd_ok (rd_ok_o)
    );

    always_comb begin
        s_d        = s_q;
        s_d.cmd    = CMD_NOP;
        take       = 1'b0;
        lock_start = sr_exit;
        unique case (s_q.st)
            ST_IDLE: begin
                if (pend && banks_idle && !burst_active) begin
                    s_d.cmd  = CMD_LOAD;
                    s_d.ba   = BA_EXT;
                    s_d.addr = ext_word;
                    s_d.gap  = GW'(GAP_CYC);
                    s_d.dll  = pend_dll;
                    s_d.st   = ST_GAP_X;
                    take     = 1'b1;
                    if (pend_dll) lock_start = 1'b1;
                end
            end
            ST_GAP_X: begin
                if (s_q.gap != '0) begin
                    s_d.gap = s_q.gap - 1'b1;
                end else if (s_q.dll) begin
                    s_d.cmd  = CMD_LOAD;
                    s_d.ba   = BA_BASE;
                    s_d.addr = base_word;
                    s_d.gap  = GW'(GAP_CYC);
                    s_d.st   = ST_GAP_B;
                end else begin
                    s_d.st = ST_IDLE;
                end
            end
            ST_GAP_B: begin
                if (s_q.gap != '0) s_d.gap = s_q.gap - 1'b1;
                else               s_d.st  = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
        s_d.busy = (s_d.st != ST_IDLE) || req_valid || (pend && !take);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.cmd  <= CMD_NOP;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_o  = s_q.cmd;
    assign ba_o   = s_q.ba;
    assign addr_o = s_q.addr;
    assign busy_o = s_q.busy;
endmodule

// File: rtl/ddr_xmode_seq_chk.sv
module ddr_xmode_seq_chk #(
    parameter int ADDR_W  = 12,
    parameter int RST_BIT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              banks_idle,
    input logic              burst_active,
    input logic              sr_exit,
    input logic [2:0]        cmd_o,
    input logic [1:0]        ba_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              busy_o,
    input logic              rd_ok_o
);
    // R2
    ext_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'b000 && ba_o == 2'b01) |-> (addr_o[ADDR_W-1:2] == '0));

    // R2
    ba_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'b000) |-> (ba_o == 2'b01 || ba_o == 2'b00));

    // R3
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'b000 && ba_o == 2'b01) |-> $past(banks_idle && !burst_active));

    // R4
    load_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'b000) |-> ($past(cmd_o) == 3'b111));

    // R5
    dll_reset_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'b000 && ba_o == 2'b00) |-> addr_o[RST_BIT]);

    // R7
    enable_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'b000 && ba_o == 2'b01 && !addr_o[0]) |-> !rd_ok_o);

    // R8
    sr_exit_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sr_exit) |-> !rd_ok_o);

    // R10
    idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cmd_o == 3'b111));
endmodule

bind ddr_xmode_seq ddr_xmode_seq_chk #(
    .ADDR_W  (ADDR_W),
    .RST_BIT (DLL_RST_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .banks_idle   (banks_idle),
    .burst_active (burst_active),
    .sr_exit      (sr_exit),
    .cmd_o        (cmd_o),
    .ba_o         (ba_o),
    .addr_o       (addr_o),
    .busy_o       (busy_o),
    .rd_ok_o      (rd_ok_o)
);

// File: tb/ddr_xmode_seq_tb.sv
module ddr_xmode_seq_tb;
    localparam int          AW   = 12;
    localparam int          GAP  = 2;
    localparam int          LOCK = 200;
    localparam int          RSTB = 8;
    localparam logic [11:0] BASE = 12'h032;
    localparam logic [2:0]  NOP  = 3'b111;
    localparam logic [2:0]  LOAD = 3'b000;

    // {dll_on, reduced}
    localparam logic [1:0] VEC [4] = '{2'b10, 2'b01, 2'b11, 2'b00};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_dll_on = 1'b0, req_reduced = 1'b0;
    logic          banks_idle = 1'b1, burst_active = 1'b0, sr_exit = 1'b0;
    logic [2:0]    cmd_o;
    logic [1:0]    ba_o;
    logic [AW-1:0] addr_o;
    logic          busy_o, rd_ok_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int en     = 0;

    ddr_xmode_seq u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_dll_on (req_dll_on), .req_reduced (req_reduced),
        .banks_idle (banks_idle), .burst_active (burst_active), .sr_exit (sr_exit),
        .cmd_o (cmd_o), .ba_o (ba_o), .addr_o (addr_o),
        .busy_o (busy_o), .rd_ok_o (rd_ok_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [11:0] ext_exp(input logic dll, input logic red);
        return {10'b0, red, ~dll};
    endfunction

    function automatic logic [11:0] base_exp();
        logic [11:0] w;
        w = BASE;
        w[RSTB] = 1'b1;
        return w;
    endfunction

    task automatic req_pulse(input logic dll, input logic red);
        @(negedge clk);
        req_valid = 1'b1; req_dll_on = dll; req_reduced = red;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_load(input logic [1:0] ba, input logic [11:0] addr, input string req);
        chk(cmd_o == LOAD, req, 32'(cmd_o), 32'(LOAD));
        chk(ba_o == ba, req, 32'(ba_o), 32'(ba));
        chk(addr_o == addr, req, 32'(addr_o), 32'(addr));
    endtask

    task automatic nops(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(cmd_o == NOP && busy_o, req, {28'b0, busy_o, cmd_o}, {28'b0, 1'b1, NOP});
        end
    endtask

    task automatic wait_lock(input string req);
        while (cyc < en + LOCK - 1) @(negedge clk);
        chk(rd_ok_o == 1'b0, req, 32'(rd_ok_o), 0);
        @(negedge clk);
        chk(rd_ok_o == 1'b1, req, 32'(rd_ok_o), 1);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cmd_o == NOP && ba_o == 2'b00 && addr_o == '0, "R1",
            {17'b0, cmd_o, ba_o, addr_o}, {17'b0, NOP, 2'b00, 12'h0});
        chk(!busy_o && !rd_ok_o, "R1", {30'b0, busy_o, rd_ok_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_o == NOP && !busy_o && !rd_ok_o, "R1", {28'b0, busy_o, cmd_o}, {28'b0, 1'b0, NOP});

        // Table walk: R2, R4, R5, R6, R7, R10
        for (int i = 0; i < 4; i++) begin
            logic dll, red;
            dll = VEC[i][1];
            red = VEC[i][0];
            req_pulse(dll, red);
            @(negedge clk);
            en = cyc;
            chk_load(2'b01, ext_exp(dll, red), "R2");
            if (dll) chk(!rd_ok_o, "R7", 32'(rd_ok_o), 0);
            else     chk(rd_ok_o, "R6", 32'(rd_ok_o), 1);
            nops(GAP, "R4");
            @(negedge clk);
            if (dll) begin
                chk_load(2'b00, base_exp(), "R5");
                nops(GAP, "R4");
                @(negedge clk);
                chk(!busy_o && cmd_o == NOP, "R10", {28'b0, busy_o, cmd_o}, {28'b0, 1'b0, NOP});
                wait_lock("R7");
            end else begin
                chk(!busy_o && cmd_o == NOP, "R6", {28'b0, busy_o, cmd_o}, {28'b0, 1'b0, NOP});
                chk(rd_ok_o, "R6", 32'(rd_ok_o), 1);
            end
        end

        // R3: held off by an active burst, then by non-idle banks
        burst_active = 1'b1;
        req_pulse(1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(cmd_o == NOP && busy_o, "R3", {28'b0, busy_o, cmd_o}, {28'b0, 1'b1, NOP});
        end
        burst_active = 1'b0;
        banks_idle   = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(cmd_o == NOP && busy_o, "R3", {28'b0, busy_o, cmd_o}, {28'b0, 1'b1, NOP});
        end
        banks_idle = 1'b1;
        @(negedge clk);
        chk_load(2'b01, ext_exp(1'b0, 1'b0), "R3");
        nops(GAP, "R4");
        @(negedge clk);
        chk(!busy_o, "R6", 32'(busy_o), 0);

        // R8: self-refresh exit restarts the lockout
        @(negedge clk);
        sr_exit = 1'b1;
        @(negedge clk);
        sr_exit = 1'b0;
        en = cyc;
        chk(!rd_ok_o, "R8", 32'(rd_ok_o), 0);
        wait_lock("R8");

        // R9: requests during a running sequence wait; the latest one is kept
        req_pulse(1'b1, 1'b0);
        @(negedge clk);
        chk_load(2'b01, ext_exp(1'b1, 1'b0), "R9");
        req_valid = 1'b1; req_dll_on = 1'b0; req_reduced = 1'b1;
        @(negedge clk);
        chk(cmd_o == NOP, "R9", 32'(cmd_o), 32'(NOP));
        req_dll_on = 1'b1; req_reduced = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(cmd_o == NOP, "R9", 32'(cmd_o), 32'(NOP));
        @(negedge clk);
        chk_load(2'b00, base_exp(), "R9");
        nops(GAP, "R9");
        @(negedge clk);
        chk(busy_o && cmd_o == NOP, "R9", {28'b0, busy_o, cmd_o}, {28'b0, 1'b1, NOP});
        @(negedge clk);
        en = cyc;
        chk_load(2'b01, ext_exp(1'b1, 1'b1), "R9");
        nops(GAP, "R4");
        @(negedge clk);
        chk_load(2'b00, base_exp(), "R5");
        nops(GAP, "R4");
        @(negedge clk);
        chk(!busy_o, "R10", 32'(busy_o), 0);
        wait_lock("R7");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule